// File: doc/BRIEF.md
# Paired Flash Block Erase and Program Sequencer

This block erases and reprograms one logical block of a flash array made of two command-set flash devices that share a 32-bit data bus. The low byte lane of the bus (bits 7:0) belongs to the even device and the next lane (bits 15:8) belongs to the odd device. Every command is written once with its byte copied into both lanes, so both devices receive it in the same bus cycle. A status word is accepted only when both devices agree. The sequencer erases the block, waits for the erase to finish and checks the result. It then fills the block one 64-byte write buffer at a time, taking the data from a staging memory port. It finishes by putting the devices back in read-array mode.

A host pulses `start` with a byte address somewhere in the target block. The sequencer raises `romWe` while it owns the flash region. At the end it pulses `done` and leaves a 3-bit result code on `errCode`. The code stays there until the next run starts. If any failure is found, the sequencer stops programming. It then clears the device status and restores read-array mode before it reports.

Top module: `flash_block_programmer`

## Requirements
- R1: After reset there is no flash read or write, `romWe` and `done` are low, and `errCode` is 0.
- R2: Every command is a single write to the block base address. Its data carries the command byte in bits 7:0 and in bits 15:8, with bits 31:16 zero. The erase is 0x20 followed by the confirm code 0xD0.
- R3: After an erase confirm, the block reads status repeatedly. No buffer request is issued until bit 7 and bit 15 are both set in one read.
- R4: An erase that completes with bit 5 or bit 13 set gives result code 1.
- R5: Each buffer starts with a 0xE8 write followed by a status read. This pair repeats until bits 7 and 15 of that read are both set.
- R6: After a buffer is ready, the block writes the word count 0x0F. It then writes the 16 staged words to consecutive word addresses of that buffer, then writes 0xD0, then polls status until bits 7 and 15 are both set. The staged word for the buffer at offset `o` is fetched at word index `o/4` within the block.
- R7: After a buffer completes, its status is decoded in a fixed priority order, where a bit set in either device counts. Bit 3 (or bit 11) gives code 2, otherwise bit 1 (or bit 9) gives code 3, otherwise bit 4 (or bit 12) gives code 4.
- R8: On any error the block writes 0x50 and then 0xFF, and then reports through `done` and `errCode`. It issues no further erase or program commands.
- R9: Buffers are written in ascending order until the whole block is covered. After the last buffer succeeds, the block writes 0xFF and then pulses `done` with code 0. `done` follows the 0xFF write by one cycle.
- R10: Address bits of `blockAddr` below BLOCK_BITS are ignored. Every flash access stays inside the selected block.
- R11: `errCode` keeps its value after `done` until the next accepted `start`, and it reads 0 in the cycle after that start.
- R12: `romWe` goes high in the cycle after an accepted `start`. It stays high through the final write and is low in the `done` cycle.
- R13: A `start` pulse, or a change of `blockAddr`, while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only while idle |
| blockAddr | input | ADDR_W | Byte address inside the target block |
| flashAddr | output | ADDR_W | Flash byte address |
| flashWdata | output | 32 | Flash write data |
| flashWe | output | 1 | Flash write strobe for this cycle |
| flashRe | output | 1 | Flash status read for this cycle |
| flashRdata | input | 32 | Flash read data, sampled at the edge ending a read cycle |
| fetchAddr | output | BLOCK_BITS-2 | Word index into the staging memory |
| fetchData | input | 32 | Staged word at `fetchAddr`, valid in the same cycle |
| romWe | output | 1 | Write enable toward the flash region while busy |
| done | output | 1 | One-cycle end-of-run pulse |
| errCode | output | 3 | Result code: 0 ok, 1 erase, 2 voltage, 3 protect, 4 program |

## Verification
The assertions check four things on every cycle. `romWe` rises after an accepted start. `errCode` cannot move while the sequencer is idle and no start is present. `done` always follows a read-array write. Programming never begins without a ready erase status showing no fault. The bench's scenarios cover the rest by comparing the complete ordered stream of flash writes, and the number of status reads, against what the requirements predict. This covers the lane copying, the buffer address walk, the retry loops, the priority of error bits that arrive together, and the cleanup order after a fault. Those behaviours depend on whole sequences and on the status values a device returns, so only scenario runs can show them.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_CMD  = 2'd1,
    BUS_DATA = 2'd2,
    BUS_STAT = 2'd3
  } busOp_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ERASE = 3'd1,
    ERR_VOLT  = 3'd2,
    ERR_PROT  = 3'd3,
    ERR_PROG  = 3'd4
  } errCode_e;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_BUFREQ  = 8'hE8;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;

  localparam int LANE_W    = 8;
  localparam int RDY_BIT   = 7;
  localparam int ERS_BIT   = 5;
  localparam int VOLT_BIT  = 3;
  localparam int PROT_BIT  = 1;
  localparam int PROG_BIT  = 4;

  typedef struct packed {
    busOp_e     busOp;
    logic [7:0] cmd;
    logic       loadBase;
    logic       incWord;
    logic       clrCount;
    logic       incBuf;
    logic       clrErr;
    logic       setErr;
    errCode_e   errVal;
  } strobe_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLOCK_BITS = 18,
  parameter int BUF_BYTES  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     blockAddr,
  output logic [ADDR_W-1:0]     flashAddr,
  output logic [31:0]           flashWdata,
  output logic                  flashWe,
  output logic                  flashRe,
  input  logic [31:0]           flashRdata,
  output logic [BLOCK_BITS-3:0] fetchAddr,
  input  logic [31:0]           fetchData,
  output logic [2:0]            errCode,
  output logic                  statReady,
  output logic                  eraseFail,
  output errCode_e              progErr,
  output logic                  lastWord,
  output logic                  lastBuf
);

  localparam int HI_W    = ADDR_W - BLOCK_BITS;
  localparam int WORDS   = BUF_BYTES / 4;
  localparam int WORD_IW = $clog2(WORDS);
  localparam int BUF_IW  = BLOCK_BITS - $clog2(BUF_BYTES);

  logic [HI_W-1:0]       baseHi;
  logic [WORD_IW-1:0]    wordIdx;
  logic [BUF_IW-1:0]     bufIdx;
  logic [2:0]            errReg;
  logic [BLOCK_BITS-1:0] byteOff;
  logic [LANE_W-1:0]     laneEven, laneOdd, laneAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi  <= '0;
      wordIdx <= '0;
      bufIdx  <= '0;
      errReg  <= ERR_NONE;
    end else begin
      if (strb.loadBase) baseHi <= blockAddr[ADDR_W-1:BLOCK_BITS];
      if (strb.clrCount) begin
        wordIdx <= '0;
        bufIdx  <= '0;
      end else begin
        if (strb.incWord) wordIdx <= wordIdx + 1'b1;
        if (strb.incBuf)  bufIdx  <= bufIdx + 1'b1;
      end
      if (strb.clrErr)      errReg <= ERR_NONE;
      else if (strb.setErr) errReg <= strb.errVal;
    end
  end

  assign byteOff   = {bufIdx, wordIdx, 2'b00};
  assign fetchAddr = {bufIdx, wordIdx};
  assign lastWord  = &wordIdx;
  assign lastBuf   = &bufIdx;
  assign errCode   = errReg;

  always_comb begin
    flashWe    = (strb.busOp == BUS_CMD) || (strb.busOp == BUS_DATA);
    flashRe    = (strb.busOp == BUS_STAT);
    flashAddr  = {baseHi, (strb.busOp == BUS_DATA) ? byteOff : {BLOCK_BITS{1'b0}}};
    flashWdata = (strb.busOp == BUS_DATA) ? fetchData : {16'h0000, strb.cmd, strb.cmd};
  end

  // Status decode: both devices must be ready; a fault in either counts.
  assign laneEven  = flashRdata[LANE_W-1:0];
  assign laneOdd   = flashRdata[2*LANE_W-1:LANE_W];
  assign laneAny   = laneEven | laneOdd;
  assign statReady = laneEven[RDY_BIT] & laneOdd[RDY_BIT];
  assign eraseFail = laneAny[ERS_BIT];

  always_comb begin
    if (laneAny[VOLT_BIT])      progErr = ERR_VOLT;
    else if (laneAny[PROT_BIT]) progErr = ERR_PROT;
    else if (laneAny[PROG_BIT]) progErr = ERR_PROG;
    else                        progErr = ERR_NONE;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     statReady,
  input  logic     eraseFail,
  input  errCode_e progErr,
  input  logic     lastWord,
  input  logic     lastBuf,
  output strobe_t  strb,
  output logic     romWe,
  output logic     done
);

  localparam logic [7:0] CMD_COUNT = 8'(BUF_BYTES / 4 - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ERS_SETUP, S_ERS_CONF, S_ERS_POLL,
    S_PRG_REQ, S_PRG_XSR, S_PRG_CNT, S_PRG_DATA,
    S_PRG_CONF, S_PRG_POLL, S_CLR_STAT, S_RD_ARRAY
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == S_RD_ARRAY);
    end
  end

  assign romWe = (state != S_IDLE);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.loadBase = 1'b1;
        strb.clrCount = 1'b1;
        strb.clrErr   = 1'b1;
        nextState     = S_ERS_SETUP;
      end
      S_ERS_SETUP: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_ERASE;   nextState = S_ERS_CONF;
      end
      S_ERS_CONF: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_CONFIRM; nextState = S_ERS_POLL;
      end
      S_ERS_POLL: begin
        strb.busOp = BUS_STAT;
        if (statReady) begin
          if (eraseFail) begin
            strb.setErr = 1'b1;
            strb.errVal = ERR_ERASE;
            nextState   = S_CLR_STAT;
          end else begin
            nextState = S_PRG_REQ;
          end
        end
      end
      S_PRG_REQ: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_BUFREQ;  nextState = S_PRG_XSR;
      end
      S_PRG_XSR: begin
        strb.busOp = BUS_STAT;
        nextState  = statReady ? S_PRG_CNT : S_PRG_REQ;
      end
      S_PRG_CNT: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_COUNT;   nextState = S_PRG_DATA;
      end
      S_PRG_DATA: begin
        strb.busOp   = BUS_DATA;
        strb.incWord = 1'b1;
        if (lastWord) nextState = S_PRG_CONF;
      end
      S_PRG_CONF: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_CONFIRM; nextState = S_PRG_POLL;
      end
      S_PRG_POLL: begin
        strb.busOp = BUS_STAT;
        if (statReady) begin
          if (progErr != ERR_NONE) begin
            strb.setErr = 1'b1;
            strb.errVal = progErr;
            nextState   = S_CLR_STAT;
          end else if (lastBuf) begin
            nextState = S_RD_ARRAY;
          end else begin
            strb.incBuf = 1'b1;
            nextState   = S_PRG_REQ;
          end
        end
      end
      S_CLR_STAT: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_CLRSTAT; nextState = S_RD_ARRAY;
      end
      S_RD_ARRAY: begin
        strb.busOp = BUS_CMD; strb.cmd = CMD_RDARRAY; nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R12
  rom_we_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == S_IDLE) |=> romWe);

  // R8
  err_code_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |-> (strb.errVal != ERR_NONE));

  // R3
  erase_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRG_REQ && $past(state) == S_ERS_POLL) |-> $past(statReady && !eraseFail));

endmodule

// File: rtl/flash_block_programmer.sv
module flash_block_programmer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLOCK_BITS = 18,
  parameter int BUF_BYTES  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     blockAddr,
  output logic [ADDR_W-1:0]     flashAddr,
  output logic [31:0]           flashWdata,
  output logic                  flashWe,
  output logic                  flashRe,
  input  logic [31:0]           flashRdata,
  output logic [BLOCK_BITS-3:0] fetchAddr,
  input  logic [31:0]           fetchData,
  output logic                  romWe,
  output logic                  done,
  output logic [2:0]            errCode
);

  strobe_t  strb;
  logic     statReady, eraseFail, lastWord, lastBuf;
  errCode_e progErr;

  flash_seq_ctrl #(.BUF_BYTES(BUF_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .statReady(statReady), .eraseFail(eraseFail), .progErr(progErr),
    .lastWord(lastWord), .lastBuf(lastBuf),
    .strb(strb), .romWe(romWe), .done(done)
  );

  flash_seq_dp #(.ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS), .BUF_BYTES(BUF_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .blockAddr(blockAddr),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashWe(flashWe),
    .flashRe(flashRe), .flashRdata(flashRdata),
    .fetchAddr(fetchAddr), .fetchData(fetchData), .errCode(errCode),
    .statReady(statReady), .eraseFail(eraseFail), .progErr(progErr),
    .lastWord(lastWord), .lastBuf(lastBuf)
  );

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!romWe && !start) |=> $stable(errCode));

  // R9
  done_after_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(flashWe) && $past(flashWdata[15:0]) == 16'hFFFF));

endmodule

// File: tb/test_flash_block_programmer.sv
module test_flash_block_programmer;

  localparam int AW  = 24;
  localparam int BB  = 8;
  localparam int BUF = 64;
  localparam int NBUF = (1 << BB) / BUF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] blockAddr = '0;
  logic [AW-1:0] flashAddr;
  logic [31:0]   flashWdata, flashRdata, fetchData;
  logic          flashWe, flashRe, romWe, done;
  logic [BB-3:0] fetchAddr;
  logic [2:0]    errCode;

  always #5 clk = ~clk;

  flash_block_programmer #(.ADDR_W(AW), .BLOCK_BITS(BB), .BUF_BYTES(BUF)) i_flash_block_programmer (
    .clk(clk), .rstN(rstN), .start(start), .blockAddr(blockAddr),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashWe(flashWe),
    .flashRe(flashRe), .flashRdata(flashRdata), .fetchAddr(fetchAddr),
    .fetchData(fetchData), .romWe(romWe), .done(done), .errCode(errCode)
  );

  int checks = 0;
  int errors = 0;

  // scenario configuration (written only by the driver)
  int          cfgEraseBusy, cfgXsrBusy, cfgProgBusy, cfgErrBuf;
  logic [15:0] cfgEraseErr, cfgProgErr;
  logic [7:0]  cfgSeed;
  logic        modelRst = 1'b0;

  function automatic logic [31:0] stageWord(input int idx, input logic [7:0] seed);
    return 32'hA500_0000 ^ (32'(idx) * 32'h0001_0203) ^ {16'h0, seed, 8'h00};
  endfunction

  assign fetchData = stageWord(int'(fetchAddr), cfgSeed);

  // flash pair model
  int phase, pollCnt, xsrCnt, curBuf;
  localparam int PH_NONE = 0, PH_ESET = 1, PH_ERS = 2, PH_XSR = 3, PH_DATA = 4, PH_PRG = 5;

  always_comb begin
    flashRdata = 32'hDEAD_0000;
    case (phase)
      PH_ERS: if (pollCnt >= cfgEraseBusy) flashRdata = 32'hDEAD_8080 | {16'h0, cfgEraseErr};
      PH_XSR: if (xsrCnt >= cfgXsrBusy)    flashRdata = 32'hDEAD_8080;
      PH_PRG: if (pollCnt >= cfgProgBusy)
                flashRdata = 32'hDEAD_8080 | ((curBuf == cfgErrBuf) ? {16'h0, cfgProgErr} : 32'h0);
      default: ;
    endcase
  end

  always @(posedge clk) begin
    if (!rstN || modelRst) begin
      phase <= PH_NONE; pollCnt <= 0; xsrCnt <= 0; curBuf <= 0;
    end else if (flashWe && flashWdata[31:16] == 16'h0) begin
      case (flashWdata[7:0])
        8'h20: phase <= PH_ESET;
        8'hE8: phase <= PH_XSR;
        8'h0F: begin phase <= PH_DATA; xsrCnt <= 0; end
        8'hD0: begin
          pollCnt <= 0;
          if (phase == PH_ESET) phase <= PH_ERS;
          else if (phase == PH_DATA) phase <= PH_PRG;
        end
        default: phase <= PH_NONE;
      endcase
    end else if (flashRe) begin
      if (phase == PH_XSR) xsrCnt <= xsrCnt + 1;
      else pollCnt <= pollCnt + 1;
      if (phase == PH_PRG && flashRdata[7] && flashRdata[15]) begin
        curBuf <= curBuf + 1;
        phase  <= PH_NONE;
      end
    end
  end

  // scoreboard
  logic [AW+31:0] expQ[$];
  int readTotal = 0;

  task automatic pushW(input logic [AW-1:0] a, input logic [31:0] d);
    expQ.push_back({a, d});
  endtask

  always @(negedge clk) begin
    if (rstN && flashRe) readTotal++;
    if (rstN && flashWe) begin
      logic [AW+31:0] e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 R6 R8 R9 unexpected write act=%h:%h exp=none", flashAddr, flashWdata);
      end else begin
        e = expQ.pop_front();
        if ({flashAddr, flashWdata} !== e || !romWe) begin
          errors++;
          $display("FAIL R2 R6 R10 R12 write act=%h:%h romWe=%b exp=%h:%h romWe=1",
                   flashAddr, flashWdata, romWe, e[AW+31:32], e[31:0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input logic [15:0] s);
    logic [7:0] o;
    o = s[7:0] | s[15:8];
    if (o[3]) return 2;
    if (o[1]) return 3;
    if (o[4]) return 4;
    return 0;
  endfunction

  task automatic runScenario(input logic [AW-1:0] req, input int eB, input int xB, input int pB,
                             input logic [15:0] eErr, input int errBuf, input logic [15:0] pErr,
                             input logic [7:0] seed, input bit poke);
    logic [AW-1:0] base;
    int code, reads, reads0, n;
    bit stop;
    cfgEraseBusy = eB; cfgXsrBusy = xB; cfgProgBusy = pB;
    cfgEraseErr = eErr; cfgErrBuf = errBuf; cfgProgErr = pErr; cfgSeed = seed;
    base = req & ~AW'((1 << BB) - 1);
    code = 0; reads = eB + 1; stop = 0;
    pushW(base, 32'h0000_2020);
    pushW(base, 32'h0000_D0D0);
    if (eErr[5] || eErr[13]) begin
      code = 1; stop = 1;
      pushW(base, 32'h0000_5050);
    end
    for (int b = 0; b < NBUF && !stop; b++) begin
      for (int r = 0; r <= xB; r++) pushW(base, 32'h0000_E8E8);
      pushW(base, 32'h0000_0F0F);
      for (int w = 0; w < BUF / 4; w++)
        pushW(base + AW'(b * BUF + w * 4), stageWord(b * (BUF / 4) + w, seed));
      pushW(base, 32'h0000_D0D0);
      reads += xB + 1 + pB + 1;
      if (b == errBuf && expCode(pErr) != 0) begin
        code = expCode(pErr); stop = 1;
        pushW(base, 32'h0000_5050);
      end
    end
    pushW(base, 32'h0000_FFFF);

    @(negedge clk) modelRst = 1'b1;
    @(negedge clk) modelRst = 1'b0;
    reads0 = readTotal;
    blockAddr = req; start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(romWe == 1'b1, "R12 romWe after start", int'(romWe), 1);
    check(errCode == 3'd0, "R11 errCode cleared by start", int'(errCode), 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      blockAddr = ~req; start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R9 done seen", int'(done), 1);
    check(int'(errCode) == code, "R4 R7 R8 result code", int'(errCode), code);
    check(romWe == 1'b0, "R12 romWe low at done", int'(romWe), 0);
    check(expQ.size() == 0, "R8 R9 writes outstanding", expQ.size(), 0);
    check(readTotal - reads0 == reads, "R3 R5 status reads", readTotal - reads0, reads);
    repeat (6) @(negedge clk);
    check(int'(errCode) == code, "R11 errCode held", int'(errCode), code);
    check(romWe == 1'b0 && done == 1'b0, "R13 no second run", int'(romWe), 0);
    expQ.delete();
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=expired exp=finished");
    finishRun();
  end

  initial begin
    cfgEraseBusy = 0; cfgXsrBusy = 0; cfgProgBusy = 0; cfgErrBuf = -1;
    cfgEraseErr = '0; cfgProgErr = '0; cfgSeed = '0;
    repeat (3) @(negedge clk);
    check(!flashWe && !flashRe && !romWe && !done && errCode == 0, "R1 reset state",
          int'({flashWe, flashRe, romWe, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!flashWe && !flashRe && !romWe && !done && errCode == 0, "R1 idle after reset",
          int'({flashWe, flashRe, romWe, done}), 0);
    // R9 R10: clean run, low address bits set
    runScenario(24'h1234A7, 2, 1, 3, 16'h0, -1, 16'h0, 8'h11, 1'b0);
    // R4: erase fault on odd device
    runScenario(24'h040000, 1, 0, 0, 16'h2000, -1, 16'h0, 8'h22, 1'b0);
    // R7: voltage beats protect and program
    runScenario(24'h3C0200, 0, 2, 1, 16'h0, 2, 16'h0A10, 8'h33, 1'b0);
    // R7: protect beats program
    runScenario(24'h000100, 0, 0, 2, 16'h0, 1, 16'h1002, 8'h44, 1'b0);
    // R7 R8: program fault on first buffer
    runScenario(24'h7F7FFF, 3, 0, 0, 16'h0, 0, 16'h0010, 8'h55, 1'b0);
    // R13: start and address change while busy
    runScenario(24'h00FF00, 0, 0, 0, 16'h0, -1, 16'h0, 8'h66, 1'b1);
    // R4: erase fault on even device
    runScenario(24'h55AA55, 0, 0, 0, 16'h0020, -1, 16'h0, 8'h77, 1'b0);
    finishRun();
  end

endmodule